// File: doc/BRIEF.md
# Card Socket Status and Interrupt Unit

This unit watches the live signals of the card sockets on a card bridge and turns their changes into host interrupts and presence events. For each socket it takes in two card-detect pins, two battery-voltage-detect pins, ready/busy, write-protect and the card's I/O interrupt request, all passed through a synchronizer. It also takes two one-cycle strobes: a general status change and an access timeout. Every change is latched into a status word that the host clears by writing ones. A control word per socket holds one enable for each latched bit, an interrupt level select and an I/O auto-mask option.

Each socket keeps a card-present (busy) flag. When both detect pins are asserted and the socket is idle, the unit records an insertion. When both are released and the socket is busy, it records a removal. Any mixed pin state records nothing. Events are tagged with the socket number and go into a small queue that the host drains by reading. The enabled pending bits of all sockets are ORed together onto one of two host interrupt lines.

Top module: `sockirq_ctrl`

## Requirements
- R1: All socket level pins pass through a synchronizer of SYNC_STAGES flops (default 2). The live copy of card-detect 1, card-detect 2, voltage-detect 1, voltage-detect 2, ready and write-protect is readable without latching in status bits 9 to 14, in that order. Status bit 15 reads the busy flag.
- R2: A latched bit is set on any edge of the synchronized input it watches. Bit 0 watches either card-detect pin, bit 1 voltage-detect 1, bit 2 voltage-detect 2, bit 3 ready and bit 4 write-protect. Bit 5 is set by the status-change strobe and bit 6 by the access-timeout strobe.
- R3: Writing the status word (address 2*socket) clears each latched bit (bits 0 to 8) written as 1. Bits written as 0 are untouched, the live bits and busy ignore writes, and a new set wins over a clear in the same cycle.
- R4: On a card-detect edge with both synchronized detect pins at 1 and the socket not busy, an insertion event (code 0) is queued and the socket becomes busy.
- R5: On a card-detect edge with both detect pins at 0 and the socket busy, a removal event (code 1) is queued and busy clears. A mixed detect state queues nothing and leaves busy unchanged.
- R6: Reading address 2*NSOCK returns the oldest event: code in bit 0, socket number from bit 1, overflow in bit 14 and valid in bit 15. A read with valid set removes the entry. Events from several sockets in the same cycle are queued in ascending socket order.
- R7: The queue holds EVQ_DEPTH events (default 4). An event that arrives when the queue is full is dropped and sets the sticky overflow bit. That bit clears only when the host writes 1 to bit 14 of the event address.
- R8: While the synchronized card interrupt is high, status bit 7 is set if the socket is busy. If the socket is not busy, spurious bit 8 is set instead and bit 7 stays clear.
- R9: The control word (address 2*socket+1) holds the enables in bits 0 to 8, the level select in bit 9 and auto-mask in bit 10. With auto-mask set, the cycle that sets bit 7 also clears enable bit 7 until the host writes the control word again.
- R10: The host interrupt is the OR over all sockets of the latched bits ANDed with their enables. It appears on host_irq_o[1] when bit 9 of socket 0's control word is 1, and on host_irq_o[0] otherwise.
- R11: After reset, every latched bit, control word, busy flag, queue entry and the overflow bit are 0, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_det_i | input | 2*NSOCK | Card-detect pins, two per socket |
| batt_det_i | input | 2*NSOCK | Voltage-detect pins, two per socket |
| ready_i | input | NSOCK | Ready/busy pin per socket |
| wprot_i | input | NSOCK | Write-protect pin per socket |
| card_irq_i | input | NSOCK | Card I/O interrupt request per socket |
| stat_chg_i | input | NSOCK | General status-change strobe per socket |
| acc_tmo_i | input | NSOCK | Access-timeout strobe per socket |
| host_wr_i | input | 1 | Register write strobe |
| host_rd_i | input | 1 | Register read strobe (pops the event queue at its address) |
| host_addr_i | input | ADDR_W | Register address |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data for the addressed register |
| host_irq_o | output | 2 | The two host interrupt lines |

## Verification
The hardest state to reach is a full event queue that is still being fed. It needs insertions and removals to alternate on one socket with no host read in between, and each pin change must wait out the synchronizer before the next one. The bench toggles both detect pins of socket 0 together six times, four cycles apart, and only then drains the queue. It then checks that four events came out in order and that overflow stays set until it is written off. A second hard case is two sockets reaching the fully detected state in the same cycle. The bench drives all four detect pins in one assignment to produce it, which exercises the ascending-socket ordering.

// File: rtl/sockirq_pkg.sv
`timescale 1ns/1ps
package sockirq_pkg;
   localparam int REG_W   = 16;
   localparam int PIN_W   = 7;
   localparam int LATCH_W = 9;
   localparam int CTRL_W  = 11;

   // synchronized pin vector positions
   localparam int P_CD1  = 0;
   localparam int P_CD2  = 1;
   localparam int P_BV1  = 2;
   localparam int P_BV2  = 3;
   localparam int P_RDY  = 4;
   localparam int P_WP   = 5;
   localparam int P_IO   = 6;

   // latched status bit positions
   localparam int B_CD   = 0;
   localparam int B_BV1  = 1;
   localparam int B_BV2  = 2;
   localparam int B_RDY  = 3;
   localparam int B_WP   = 4;
   localparam int B_SC   = 5;
   localparam int B_TMO  = 6;
   localparam int B_IO   = 7;
   localparam int B_SPUR = 8;

   // control word extras
   localparam int C_LVL  = 9;
   localparam int C_AUTO = 10;

   // event word
   localparam int EV_OVF = 14;
   localparam int EV_VLD = 15;

   typedef enum logic {EV_INSERT = 1'b0, EV_REMOVE = 1'b1} ev_code_e;
endpackage

// File: rtl/sockirq_sync.sv
`timescale 1ns/1ps
module sockirq_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] st [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("sockirq_sync: STAGES below 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d_i;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) st[k] <= '0;
         else        st[k] <= st[k-1];
      end
   end

   assign q_o = st[STAGES-1];
endmodule

// File: rtl/sockirq_socket.sv
`timescale 1ns/1ps
module sockirq_socket
   import sockirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  pins_i,
   input  logic              sc_stb_i,
   input  logic              tmo_stb_i,
   input  logic              stat_wr_i,
   input  logic              ctrl_wr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [REG_W-1:0]  stat_o,
   output logic [REG_W-1:0]  ctrl_o,
   output logic              pend_o,
   output logic              ins_o,
   output logic              rem_o
);
   logic [PIN_W-1:0]   live, live_q;
   logic [LATCH_W-1:0] latch_q, set_v, clr_v;
   logic [CTRL_W-1:0]  ctrl_q;
   logic               busy_q, cd_edge;

   sockirq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_i),
      .q_o  (live)
   );

   assign cd_edge = (live[P_CD2:P_CD1] != live_q[P_CD2:P_CD1]);
   assign ins_o   = cd_edge && (live[P_CD2:P_CD1] == 2'b11) && !busy_q;
   assign rem_o   = cd_edge && (live[P_CD2:P_CD1] == 2'b00) && busy_q;
   assign clr_v   = stat_wr_i ? wdata_i[LATCH_W-1:0] : '0;

   always_comb begin
      set_v         = '0;
      set_v[B_CD]   = cd_edge;
      set_v[B_BV1]  = live[P_BV1] ^ live_q[P_BV1];
      set_v[B_BV2]  = live[P_BV2] ^ live_q[P_BV2];
      set_v[B_RDY]  = live[P_RDY] ^ live_q[P_RDY];
      set_v[B_WP]   = live[P_WP]  ^ live_q[P_WP];
      set_v[B_SC]   = sc_stb_i;
      set_v[B_TMO]  = tmo_stb_i;
      set_v[B_IO]   = live[P_IO] & busy_q;
      set_v[B_SPUR] = live[P_IO] & ~busy_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q  <= '0;
         busy_q  <= 1'b0;
         latch_q <= '0;
         ctrl_q  <= '0;
      end else begin
         live_q  <= live;
         if (ins_o)      busy_q <= 1'b1;
         else if (rem_o) busy_q <= 1'b0;
         latch_q <= (latch_q & ~clr_v) | set_v;
         if (ctrl_wr_i)
            ctrl_q <= wdata_i;
         else if (ctrl_q[C_AUTO] && set_v[B_IO])
            ctrl_q[B_IO] <= 1'b0;
      end
   end

   assign stat_o = {busy_q, live[P_WP:P_CD1], latch_q};
   assign ctrl_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
   assign pend_o = |(latch_q & ctrl_q[LATCH_W-1:0]);

   // R4: busy only rises after both detect pins were seen asserted
   assert_ins_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(live[P_CD2:P_CD1]) == 2'b11);
   // R5: busy only falls after both detect pins were seen released
   assert_rem_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(live[P_CD2:P_CD1]) == 2'b00);
   // R8: spurious flag only rises for an idle socket
   assert_spur_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q[B_SPUR]) |-> !$past(busy_q));
   // R9: auto-mask drops the I/O enable after a forwarded request
   assert_automask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[C_AUTO] && live[P_IO] && busy_q && !ctrl_wr_i) |=> !ctrl_q[B_IO]);
   // R3: a written one clears a bit that is not being set again
   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i && wdata_i[B_TMO] && !tmo_stb_i) |=> !latch_q[B_TMO]);
endmodule

// File: rtl/sockirq_evq.sv
`timescale 1ns/1ps
module sockirq_evq #(
   parameter int DEPTH = 4,
   parameter int NPUSH = 2,
   parameter int EW    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPUSH-1:0]  push_i,
   input  logic [NPUSH*EW-1:0] ent_i,
   input  logic              pop_i,
   input  logic              ovf_clr_i,
   output logic [EW-1:0]     head_o,
   output logic              valid_o,
   output logic              ovf_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   logic [EW-1:0] mem_q [DEPTH];
   logic [EW-1:0] mem_n [DEPTH];
   logic [PW-1:0] rp_q, rp_n, wp_q, wp_n;
   logic [CW-1:0] cnt_q, cnt_n;
   logic          ovf_q, ovf_n;

   initial begin
      assert (DEPTH >= 2 && (1 << PW) == DEPTH)
         else $error("sockirq_evq: DEPTH must be a power of two");
   end

   always_comb begin
      mem_n = mem_q;
      rp_n  = rp_q;
      wp_n  = wp_q;
      cnt_n = cnt_q;
      ovf_n = ovf_q & ~ovf_clr_i;
      if (pop_i && cnt_q != '0) begin
         rp_n  = rp_q + PW'(1);
         cnt_n = cnt_q - CW'(1);
      end
      for (int k = 0; k < NPUSH; k++) begin
         if (push_i[k]) begin
            if (cnt_n < CW'(DEPTH)) begin
               mem_n[wp_n] = ent_i[k*EW +: EW];
               wp_n        = wp_n + PW'(1);
               cnt_n       = cnt_n + CW'(1);
            end else begin
               ovf_n = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp_q  <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else begin
         rp_q  <= rp_n;
         wp_q  <= wp_n;
         cnt_q <= cnt_n;
         ovf_q <= ovf_n;
         mem_q <= mem_n;
      end
   end

   assign head_o  = mem_q[rp_q];
   assign valid_o = (cnt_q != '0);
   assign ovf_o   = ovf_q;

   // R7: occupancy never exceeds the depth
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   // R7: an event arriving at a full queue raises overflow
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|push_i && cnt_q == CW'(DEPTH) && !pop_i) |=> ovf_q);
   // R7: overflow stays until explicitly cleared
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/sockirq_ctrl.sv
`timescale 1ns/1ps
module sockirq_ctrl
   import sockirq_pkg::*;
#(
   parameter int NSOCK       = 2,
   parameter int EVQ_DEPTH   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(2*NSOCK+1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*NSOCK-1:0]   card_det_i,
   input  logic [2*NSOCK-1:0]   batt_det_i,
   input  logic [NSOCK-1:0]     ready_i,
   input  logic [NSOCK-1:0]     wprot_i,
   input  logic [NSOCK-1:0]     card_irq_i,
   input  logic [NSOCK-1:0]     stat_chg_i,
   input  logic [NSOCK-1:0]     acc_tmo_i,
   input  logic                 host_wr_i,
   input  logic                 host_rd_i,
   input  logic [ADDR_W-1:0]    host_addr_i,
   input  logic [REG_W-1:0]     host_wdata_i,
   output logic [REG_W-1:0]     host_rdata_o,
   output logic [1:0]           host_irq_o
);
   localparam int SW       = (NSOCK > 1) ? $clog2(NSOCK) : 1;
   localparam int EW       = SW + 1;
   localparam int EVQ_ADDR = 2 * NSOCK;

   initial begin
      assert (NSOCK >= 1 && EW <= EV_OVF)
         else $error("sockirq_ctrl: socket field does not fit the event word");
   end

   logic [REG_W-1:0]   stat_a [NSOCK];
   logic [REG_W-1:0]   ctrl_a [NSOCK];
   logic [NSOCK-1:0]   pend, ins, rem, push;
   logic [NSOCK*EW-1:0] ent;
   logic [EW-1:0]      ev_head;
   logic               ev_valid, ev_ovf, ev_pop, ev_clr, any_irq;
   logic [REG_W-1:0]   ev_word;

   for (genvar i = 0; i < NSOCK; i++) begin : g_sock
      logic [PIN_W-1:0] pins;
      assign pins = {card_irq_i[i], wprot_i[i], ready_i[i],
                     batt_det_i[2*i+1], batt_det_i[2*i],
                     card_det_i[2*i+1], card_det_i[2*i]};

      sockirq_socket #(.SYNC_STAGES(SYNC_STAGES)) u_sock (
         .clk      (clk),
         .rst_n    (rst_n),
         .pins_i   (pins),
         .sc_stb_i (stat_chg_i[i]),
         .tmo_stb_i(acc_tmo_i[i]),
         .stat_wr_i(host_wr_i && host_addr_i == ADDR_W'(2*i)),
         .ctrl_wr_i(host_wr_i && host_addr_i == ADDR_W'(2*i+1)),
         .wdata_i  (host_wdata_i[CTRL_W-1:0]),
         .stat_o   (stat_a[i]),
         .ctrl_o   (ctrl_a[i]),
         .pend_o   (pend[i]),
         .ins_o    (ins[i]),
         .rem_o    (rem[i])
      );

      assign push[i]            = ins[i] | rem[i];
      assign ent[i*EW +: EW]    = {SW'(i), rem[i] ? EV_REMOVE : EV_INSERT};
   end

   assign ev_pop = host_rd_i && host_addr_i == ADDR_W'(EVQ_ADDR);
   assign ev_clr = host_wr_i && host_addr_i == ADDR_W'(EVQ_ADDR) && host_wdata_i[EV_OVF];

   sockirq_evq #(.DEPTH(EVQ_DEPTH), .NPUSH(NSOCK), .EW(EW)) u_evq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (push),
      .ent_i    (ent),
      .pop_i    (ev_pop),
      .ovf_clr_i(ev_clr),
      .head_o   (ev_head),
      .valid_o  (ev_valid),
      .ovf_o    (ev_ovf)
   );

   always_comb begin
      ev_word         = '0;
      ev_word[EW-1:0] = ev_valid ? ev_head : '0;
      ev_word[EV_OVF] = ev_ovf;
      ev_word[EV_VLD] = ev_valid;
   end

   always_comb begin
      host_rdata_o = '0;
      for (int i = 0; i < NSOCK; i++) begin
         if (host_addr_i == ADDR_W'(2*i))   host_rdata_o = stat_a[i];
         if (host_addr_i == ADDR_W'(2*i+1)) host_rdata_o = ctrl_a[i];
      end
      if (host_addr_i == ADDR_W'(EVQ_ADDR)) host_rdata_o = ev_word;
   end

   assign any_irq    = |pend;
   assign host_irq_o = {any_irq & ctrl_a[0][C_LVL], any_irq & ~ctrl_a[0][C_LVL]};
endmodule

// File: tb/tb_sockirq_ctrl.sv
`timescale 1ns/1ps
module tb_sockirq_ctrl;
   localparam int NS = 2;
   localparam int QD = 4;
   localparam logic [2:0] EVA = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  card_det = '0, batt_det = '0;
   logic [1:0]  ready = '0, wprot = '0, card_irq = '0, stat_chg = '0, acc_tmo = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [1:0]  host_irq;

   int nchk = 0, nfail = 0;

   always #10 clk = ~clk;  // 50 MHz

   sockirq_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .card_det_i(card_det), .batt_det_i(batt_det), .ready_i(ready),
      .wprot_i(wprot), .card_irq_i(card_irq), .stat_chg_i(stat_chg),
      .acc_tmo_i(acc_tmo), .host_wr_i(host_wr), .host_rd_i(host_rd),
      .host_addr_i(host_addr), .host_wdata_i(host_wdata),
      .host_rdata_o(host_rdata), .host_irq_o(host_irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [6:0]  m1 [NS];
   logic [6:0]  ms [NS];
   logic [6:0]  mprev [NS];
   logic [8:0]  mlatch [NS];
   logic [10:0] mctrl [NS];
   logic        mbusy [NS];
   logic        movf;
   int          mq [$];
   logic [6:0]  pv;
   logic [8:0]  st;
   logic        cdc;

   task automatic mpush(int v);
      if (mq.size() < QD) mq.push_back(v);
      else movf = 1'b1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m1[i] = '0; ms[i] = '0; mprev[i] = '0;
            mlatch[i] = '0; mctrl[i] = '0; mbusy[i] = 1'b0;
         end
         mq.delete();
         movf = 1'b0;
      end else begin
         if (host_rd && host_addr == EVA && mq.size() > 0) void'(mq.pop_front());
         if (host_wr && host_addr == EVA && host_wdata[14]) movf = 1'b0;
         for (int i = 0; i < NS; i++) begin
            pv = {card_irq[i], wprot[i], ready[i], batt_det[2*i+1], batt_det[2*i],
                  card_det[2*i+1], card_det[2*i]};
            cdc = (ms[i][1:0] != mprev[i][1:0]);
            st = '0;
            st[0] = cdc;
            st[1] = ms[i][2] != mprev[i][2];
            st[2] = ms[i][3] != mprev[i][3];
            st[3] = ms[i][4] != mprev[i][4];
            st[4] = ms[i][5] != mprev[i][5];
            st[5] = stat_chg[i];
            st[6] = acc_tmo[i];
            st[7] = ms[i][6] && mbusy[i];
            st[8] = ms[i][6] && !mbusy[i];
            if (cdc && ms[i][1:0] == 2'b11 && !mbusy[i]) begin
               mpush(i*2); mbusy[i] = 1'b1;
            end else if (cdc && ms[i][1:0] == 2'b00 && mbusy[i]) begin
               mpush(i*2+1); mbusy[i] = 1'b0;
            end
            if (host_wr && host_addr == 3'(2*i)) mlatch[i] = mlatch[i] & ~host_wdata[8:0];
            mlatch[i] = mlatch[i] | st;
            if (host_wr && host_addr == 3'(2*i+1)) mctrl[i] = host_wdata[10:0];
            else if (mctrl[i][10] && st[7]) mctrl[i][7] = 1'b0;
            mprev[i] = ms[i]; ms[i] = m1[i]; m1[i] = pv;
         end
      end
   end

   function automatic logic [15:0] exp_rd(logic [2:0] a);
      if (a < 3'(2*NS)) begin
         if (a[0]) return {5'b0, mctrl[a/2]};
         return {mbusy[a/2], ms[a/2][5:0], mlatch[a/2]};
      end
      if (a == EVA) begin
         if (mq.size() > 0) return {1'b1, movf, 12'b0, 2'(mq[0])};
         return {1'b0, movf, 14'b0};
      end
      return 16'h0;
   endfunction

   function automatic logic [1:0] exp_irq();
      logic any = 1'b0;
      for (int i = 0; i < NS; i++) any |= |(mlatch[i] & mctrl[i][8:0]);
      return mctrl[0][9] ? {any, 1'b0} : {1'b0, any};
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R10 irq lines", {14'b0, host_irq}, {14'b0, exp_irq()});
         if (host_addr == EVA)   chk("R6 event word", host_rdata, exp_rd(host_addr));
         else if (host_addr[0])  chk("R9 control word", host_rdata, exp_rd(host_addr));
         else                    chk("R3 status word", host_rdata, exp_rd(host_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(posedge clk); #5;
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #5;
      host_wr = 1'b0;
   endtask

   task automatic peek(logic [2:0] a, logic [15:0] mask, logic [15:0] exp, string req);
      @(posedge clk); #5;
      host_addr = a;
      @(negedge clk);
      chk(req, host_rdata & mask, exp);
   endtask

   task automatic rd_ev(logic [15:0] exp, string req);
      @(posedge clk); #5;
      host_addr = EVA; host_rd = 1'b1;
      @(negedge clk);
      chk(req, host_rdata, exp);
      @(posedge clk); #5;
      host_rd = 1'b0;
   endtask

   task automatic chk_irq(logic [1:0] exp, string req);
      @(negedge clk);
      chk(req, {14'b0, host_irq}, {14'b0, exp});
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R11 reset state
      peek(3'd0, 16'hFFFF, 16'h0000, "R11 status0 after reset");
      peek(3'd3, 16'hFFFF, 16'h0000, "R11 control1 after reset");
      peek(EVA,  16'hFFFF, 16'h0000, "R11 event queue after reset");
      chk_irq(2'b00, "R11 irq after reset");

      wr(3'd1, 16'h01FF);
      wr(3'd3, 16'h01FF);
      wr(3'd0, 16'h3FFF);
      wr(3'd2, 16'h3FFF);

      // R4 insertion on socket 0, R1 live bits
      @(posedge clk); #5; card_det[1:0] = 2'b11;
      cyc(5);
      peek(3'd0, 16'h8601, 16'h8601, "R4 busy, R1 live detect, R2 change bit");
      chk_irq(2'b01, "R10 irq on line 0");
      rd_ev(16'h8000, "R6 insertion socket 0");
      peek(EVA, 16'hFFFF, 16'h0000, "R6 queue empty after pop");

      // R5 mixed state on socket 1
      @(posedge clk); #5; card_det[2] = 1'b1;
      cyc(5);
      peek(3'd2, 16'h8601, 16'h0201, "R5 mixed state no busy");
      peek(EVA, 16'h8000, 16'h0000, "R5 mixed state no event");

      // R3 write-one-to-clear
      wr(3'd0, 16'h0000);
      peek(3'd0, 16'h0001, 16'h0001, "R3 zero write keeps bit");
      wr(3'd0, 16'h7E01);
      peek(3'd0, 16'hFFFF, 16'h8600, "R3 one clears, live and busy unaffected");
      wr(3'd2, 16'h3FFF);
      chk_irq(2'b00, "R10 irq low after clear");

      // R8 spurious on idle socket 1
      @(posedge clk); #5; card_irq[1] = 1'b1;
      cyc(5);
      peek(3'd2, 16'h0180, 16'h0100, "R8 spurious bit on idle socket");
      @(posedge clk); #5; card_irq[1] = 1'b0;
      cyc(4);
      wr(3'd2, 16'h3FFF);

      // R9 auto-mask on busy socket 0
      wr(3'd1, 16'h05FF);
      @(posedge clk); #5; card_irq[0] = 1'b1;
      cyc(5);
      peek(3'd0, 16'h0180, 16'h0080, "R8 forwarded request bit");
      peek(3'd1, 16'hFFFF, 16'h057F, "R9 enable bit 7 masked");
      @(posedge clk); #5; card_irq[0] = 1'b0;
      cyc(4);
      wr(3'd0, 16'h0080);
      wr(3'd1, 16'h05FF);
      peek(3'd1, 16'hFFFF, 16'h05FF, "R9 re-armed by host write");

      // R10 level select, R2 strobes
      wr(3'd1, 16'h07FF);
      @(posedge clk); #5; stat_chg[1] = 1'b1;
      @(posedge clk); #5; stat_chg[1] = 1'b0;
      chk_irq(2'b10, "R10 irq on line 1");
      peek(3'd2, 16'h0060, 16'h0020, "R2 status-change strobe bit");
      @(posedge clk); #5; acc_tmo[1] = 1'b1;
      @(posedge clk); #5; acc_tmo[1] = 1'b0;
      peek(3'd2, 16'h0060, 16'h0060, "R2 timeout strobe bit");
      wr(3'd2, 16'h3FFF);
      chk_irq(2'b00, "R10 irq low after clear");

      // R5 removal on socket 0
      @(posedge clk); #5; card_det[1:0] = 2'b00;
      cyc(5);
      peek(3'd0, 16'h8000, 16'h0000, "R5 busy cleared");
      rd_ev(16'h8001, "R5 removal event socket 0");

      // R6 simultaneous insertion, ascending order
      @(posedge clk); #5; card_det = 4'b1111;
      cyc(5);
      rd_ev(16'h8000, "R6 first socket 0");
      rd_ev(16'h8002, "R6 then socket 1");

      // R7 overflow
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #5; card_det[1:0] = (k % 2 == 0) ? 2'b00 : 2'b11;
         cyc(4);
      end
      cyc(2);
      peek(EVA, 16'hC000, 16'hC000, "R7 overflow with full queue");
      rd_ev(16'hC001, "R7 oldest kept event");
      rd_ev(16'hC000, "R7 second event");
      rd_ev(16'hC001, "R7 third event");
      rd_ev(16'hC000, "R7 fourth event");
      peek(EVA, 16'hC000, 16'h4000, "R7 overflow sticky when empty");
      wr(EVA, 16'h4000);
      peek(EVA, 16'hFFFF, 16'h0000, "R7 overflow cleared");

      // R2 voltage, ready and write-protect edges, R1 live copies
      wr(3'd0, 16'h3FFF);
      @(posedge clk); #5; batt_det[0] = 1'b1; ready[0] = 1'b1; wprot[0] = 1'b1;
      cyc(5);
      peek(3'd0, 16'h781E, 16'h681A, "R2 edge bits, R1 live bits");

      cyc(3);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule